// File: doc/BRIEF.md
# Accumulator Register-Reference Execute Unit

This unit carries out the register-reference group of a small accumulator machine. It owns the 16-bit accumulator and the one-bit extend (carry) flip-flop. When the control sequencer reaches execute step 3 with an instruction word whose three class bits are all ones and whose indirect bit is clear, the low twelve instruction bits are taken as a field of independent operation bits. The unit rewrites the accumulator and extend bit at the clock edge that ends the step. During that same step it raises three strobes for the rest of the machine: a skip request (the program counter steps once more), a halt strobe (the start-stop flip-flop clears) and a sequence-counter clear.

Although a program normally sets one operation bit, several may be set together. Clears act first, then complements, then a right rotate, then a left rotate, then the increment. Skip tests always read the accumulator and extend values held at the start of the step, so a skip never sees the result of the same instruction.

Top module: `acc_regref_exec`

## Requirements
- R1: The unit is active only when instr[14:12] is 3'b111, instr[15] is 0 and step equals 3; in any other cycle acc_q and ext_q keep their values and skip_req, halt_req and seq_clr are 0.
- R2: seq_clr is 1 in every active cycle, including one whose operation field instr[11:0] is all zeros, which leaves acc_q and ext_q unchanged.
- R3: instr[11] clears the accumulator and instr[10] clears the extend bit; clears act before every other operation bit.
- R4: instr[9] inverts every accumulator bit and instr[8] inverts the extend bit, acting on the values left by the clears.
- R5: instr[7] rotates right through the 17-bit ring: acc bit 15 takes the extend value and the extend bit takes acc bit 0.
- R6: instr[6] rotates left through the ring: acc bit 0 takes the extend value and the extend bit takes acc bit 15; it acts after the right rotate, so both bits together leave the ring unchanged.
- R7: instr[5] adds one to the accumulator modulo 2^16 as the last operation and never changes the extend bit.
- R8: skip_req is 1 in an active cycle when any of these hold on the start-of-step values: instr[4] and acc bit 15 is 0; instr[3] and acc bit 15 is 1; instr[2] and acc is zero; instr[1] and extend is 0. It is a single strobe whatever number of tests pass.
- R9: halt_req equals instr[0] in an active cycle.
- R10: A synchronous active-low reset clears the accumulator and the extend bit; the results of an active cycle appear on acc_q and ext_q after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 16 | Instruction word: bit 15 indirect, 14:12 class, 11:0 operation bits |
| step | input | 4 | Current timing step from the sequence counter |
| acc_q | output | 16 | Accumulator |
| ext_q | output | 1 | Extend bit |
| skip_req | output | 1 | Skip the next instruction (one extra program counter step) |
| halt_req | output | 1 | Clear the start-stop flip-flop |
| seq_clr | output | 1 | Clear the sequence counter |

## Verification
The assertions take the instruction word and step as settled for the whole cycle and valid from the first clock after reset, and the operation checks fire only on fields with a single operation bit set, since combined fields follow the ordering rule instead. The bench therefore changes inputs only at the falling edge, parks the step at zero between instructions, and reaches every accumulator value through the unit's own operations: each load is a clear followed by sixteen left rotates that feed one chosen bit through the extend flip-flop.

// File: rtl/acc_regref_pkg.sv
// Package: shared instruction format and the decoded operation set.
// Assumes a 16-bit instruction word with bit 15 indirect, 14:12 class, 11:0 operation bits.
package acc_regref_pkg;

    localparam int INSTR_W   = 16;
    localparam int FIELD_W   = 12;
    localparam int CLASS_LSB = 12;
    localparam int IND_BIT   = 15;
    localparam logic [2:0] REGREF_CLASS = 3'b111;

    // Operation bit positions inside instr[11:0]
    localparam int B_CLR_ACC = 11;
    localparam int B_CLR_EXT = 10;
    localparam int B_INV_ACC = 9;
    localparam int B_INV_EXT = 8;
    localparam int B_ROT_R   = 7;
    localparam int B_ROT_L   = 6;
    localparam int B_INC     = 5;
    localparam int B_SK_POS  = 4;
    localparam int B_SK_NEG  = 3;
    localparam int B_SK_ZERO = 2;
    localparam int B_SK_EZ   = 1;
    localparam int B_HALT    = 0;

    localparam int NUM_SKIP_TESTS = 4;

    typedef struct packed {
        logic clr_acc;
        logic clr_ext;
        logic inv_acc;
        logic inv_ext;
        logic rot_r;
        logic rot_l;
        logic inc;
        logic [NUM_SKIP_TESTS-1:0] skip_sel;  // [3]=sign 0, [2]=sign 1, [1]=acc zero, [0]=ext 0
        logic halt;
    } op_set_t;

    // Split the operation field into named controls, gated by the active flag.
    function automatic op_set_t split_field(input logic [FIELD_W-1:0] fld, input logic en);
        op_set_t o;
        o.clr_acc  = en & fld[B_CLR_ACC];
        o.clr_ext  = en & fld[B_CLR_EXT];
        o.inv_acc  = en & fld[B_INV_ACC];
        o.inv_ext  = en & fld[B_INV_EXT];
        o.rot_r    = en & fld[B_ROT_R];
        o.rot_l    = en & fld[B_ROT_L];
        o.inc      = en & fld[B_INC];
        o.skip_sel = {NUM_SKIP_TESTS{en}} & fld[B_SK_POS:B_SK_EZ];
        o.halt     = en & fld[B_HALT];
        return o;
    endfunction

endpackage

// File: rtl/acc_regref_decode.sv
// Decode: recognises a register-reference instruction in the execute step and
// splits its operation field. Assumes instr and step are stable through the cycle.
module acc_regref_decode
    import acc_regref_pkg::*;
#(
    parameter int STEP_W    = 4,
    parameter int EXEC_STEP = 3
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [STEP_W-1:0]  step,
    output logic               active,
    output op_set_t            ops
);
    localparam logic [STEP_W-1:0] EXEC_STEP_V = STEP_W'(EXEC_STEP);

    logic class_hit;
    logic step_hit;

    // Match the class bits, the direct mode and the execute step.
    always_comb begin
        class_hit = (instr[CLASS_LSB +: 3] == REGREF_CLASS) && !instr[IND_BIT];
        step_hit  = (step == EXEC_STEP_V);
        active    = class_hit && step_hit;
        ops       = split_field(instr[FIELD_W-1:0], active);
    end

endmodule

// File: rtl/acc_regref_datapath.sv
// Datapath: computes the next accumulator and extend values by applying, in order,
// clears, complements, right rotate, left rotate and increment. Assumes DATA_W >= 2.
module acc_regref_datapath
    import acc_regref_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] acc_cur,
    input  logic              ext_cur,
    input  op_set_t           ops,
    output logic [DATA_W-1:0] acc_nxt,
    output logic              ext_nxt
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] a_clr, a_inv, a_rr, a_rl;
    logic              e_clr, e_inv, e_rr, e_rl;

    // Stage 1 and 2: clears then complements.
    always_comb begin
        a_clr = ops.clr_acc ? '0 : acc_cur;
        e_clr = ops.clr_ext ? 1'b0 : ext_cur;
        a_inv = ops.inv_acc ? ~a_clr : a_clr;
        e_inv = ops.inv_ext ? ~e_clr : e_clr;
    end

    // Stage 3: rotate right through the extend bit.
    always_comb begin
        if (ops.rot_r) begin
            a_rr = {e_inv, a_inv[DATA_W-1:1]};
            e_rr = a_inv[0];
        end else begin
            a_rr = a_inv;
            e_rr = e_inv;
        end
    end

    // Stage 4: rotate left through the extend bit.
    always_comb begin
        if (ops.rot_l) begin
            a_rl = {a_rr[DATA_W-2:0], e_rr};
            e_rl = a_rr[DATA_W-1];
        end else begin
            a_rl = a_rr;
            e_rl = e_rr;
        end
    end

    // Stage 5: wrapping increment; extend bit untouched.
    always_comb begin
        acc_nxt = ops.inc ? (a_rl + ONE) : a_rl;
        ext_nxt = e_rl;
    end

endmodule

// File: rtl/acc_regref_skip.sv
// Skip evaluator: forms one skip strobe from the selected tests on the values
// held at the start of the step. Assumes skip_sel is already gated by the active flag.
module acc_regref_skip
    import acc_regref_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]         acc_cur,
    input  logic                      ext_cur,
    input  logic [NUM_SKIP_TESTS-1:0] skip_sel,
    output logic                      skip
);
    logic [NUM_SKIP_TESTS-1:0] cond;
    logic [NUM_SKIP_TESTS-1:0] hit;

    // Conditions in the same order as skip_sel.
    always_comb begin
        cond[3] = !acc_cur[DATA_W-1];
        cond[2] =  acc_cur[DATA_W-1];
        cond[1] = (acc_cur == '0);
        cond[0] = !ext_cur;
    end

    for (genvar g = 0; g < NUM_SKIP_TESTS; g++) begin : g_test
        // Each test passes only when its bit is selected.
        always_comb hit[g] = skip_sel[g] & cond[g];
    end

    // Any passing test gives one strobe.
    always_comb skip = |hit;

endmodule

// File: rtl/acc_regref_exec.sv
// Top: register-reference execute unit. Holds the accumulator and extend bit,
// updates them at the edge ending the execute step and drives the step strobes.
// Assumes the sequencer acts on skip_req, halt_req and seq_clr in the same cycle.
module acc_regref_exec
    import acc_regref_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int STEP_W    = 4,
    parameter int EXEC_STEP = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic [STEP_W-1:0]  step,
    output logic [DATA_W-1:0]  acc_q,
    output logic               ext_q,
    output logic               skip_req,
    output logic               halt_req,
    output logic               seq_clr
);
    logic              active;
    op_set_t           ops;
    logic [DATA_W-1:0] acc_nxt;
    logic              ext_nxt;
    logic              skip_w;

    acc_regref_decode #(.STEP_W(STEP_W), .EXEC_STEP(EXEC_STEP)) u_dec (
        .instr  (instr),
        .step   (step),
        .active (active),
        .ops    (ops)
    );

    acc_regref_datapath #(.DATA_W(DATA_W)) u_dp (
        .acc_cur (acc_q),
        .ext_cur (ext_q),
        .ops     (ops),
        .acc_nxt (acc_nxt),
        .ext_nxt (ext_nxt)
    );

    acc_regref_skip #(.DATA_W(DATA_W)) u_skip (
        .acc_cur  (acc_q),
        .ext_cur  (ext_q),
        .skip_sel (ops.skip_sel),
        .skip     (skip_w)
    );

    // Accumulator and extend registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ext_q <= 1'b0;
        end else if (active) begin
            acc_q <= acc_nxt;
            ext_q <= ext_nxt;
        end
    end

    // Step strobes, valid only in the active cycle.
    always_comb begin
        skip_req = skip_w;
        halt_req = ops.halt;
        seq_clr  = active;
    end

endmodule

// File: rtl/acc_regref_exec_chk.sv
// Checker: temporal properties of the execute unit, bound to the top module.
// Assumes instr and step settle before each rising edge.
module acc_regref_exec_chk #(
    parameter int DATA_W = 16,
    parameter int STEP_W = 4,
    parameter int EXEC_STEP = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       instr,
    input logic [STEP_W-1:0] step,
    input logic [DATA_W-1:0] acc_q,
    input logic              ext_q,
    input logic              skip_req,
    input logic              halt_req,
    input logic              seq_clr
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [STEP_W-1:0] EXEC_V = STEP_W'(EXEC_STEP);

    logic act;
    logic [DATA_W-1:0] acc_plus;
    // Port-level view of an active cycle and the increment target.
    always_comb begin
        act      = (instr[14:12] == 3'b111) && !instr[15] && (step == EXEC_V);
        acc_plus = acc_q + ONE;
    end

    assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (acc_q == $past(acc_q)) && (ext_q == $past(ext_q)));
    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> !skip_req && !halt_req && !seq_clr);
    assert_seq_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> seq_clr);
    assert_clear_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act && (instr[11:0] == 12'h800) |=> (acc_q == '0) && (ext_q == $past(ext_q)));
    assert_invert_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act && (instr[11:0] == 12'h200) |=> (acc_q == ~$past(acc_q)));
    assert_rot_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act && (instr[11:0] == 12'h080) |=>
            (ext_q == $past(acc_q[0])) && (acc_q[DATA_W-1] == $past(ext_q)));
    assert_rot_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        act && (instr[11:0] == 12'h040) |=>
            (ext_q == $past(acc_q[DATA_W-1])) && (acc_q[0] == $past(ext_q)));
    assert_increment_R7: assert property (@(posedge clk) disable iff (!rst_n)
        act && (instr[11:0] == 12'h020) |=>
            (acc_q == $past(acc_plus)) && (ext_q == $past(ext_q)));
    assert_skip_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        act && instr[3] && acc_q[DATA_W-1] |-> skip_req);
    assert_skip_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        act && (instr[4:1] == 4'b0000) |-> !skip_req);
    assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> (halt_req == instr[0]));
    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0) && !ext_q);

endmodule

bind acc_regref_exec acc_regref_exec_chk #(
    .DATA_W(DATA_W), .STEP_W(STEP_W), .EXEC_STEP(EXEC_STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .instr(instr), .step(step),
    .acc_q(acc_q), .ext_q(ext_q), .skip_req(skip_req),
    .halt_req(halt_req), .seq_clr(seq_clr)
);

// File: tb/acc_regref_exec_tb_top.sv
`timescale 1ns/1ps
// Bench: vector table of operation fields with start and expected values,
// then directed tests for reset and inactive cycles.
module acc_regref_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [3:0]  step = 4'd0;
    logic [15:0] acc_q;
    logic        ext_q;
    logic        skip_req, halt_req, seq_clr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic cap_skip, cap_halt, cap_clr;

    always #2.5 clk = ~clk;

    acc_regref_exec dut_i (
        .clk(clk), .rst_n(rst_n), .instr(instr), .step(step),
        .acc_q(acc_q), .ext_q(ext_q), .skip_req(skip_req),
        .halt_req(halt_req), .seq_clr(seq_clr)
    );

    typedef struct packed {
        logic [11:0] fld;
        logic [15:0] a0;
        logic        e0;
        logic [15:0] xa;
        logic        xe;
        logic        xs;
        logic        xh;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{12'h800, 16'h1234, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0}, // R3 clear acc
        '{12'h400, 16'h1234, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0}, // R3 clear ext
        '{12'h200, 16'h00FF, 1'b0, 16'hFF00, 1'b0, 1'b0, 1'b0}, // R4 invert acc
        '{12'h100, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R4 invert ext
        '{12'h080, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R5
        '{12'h080, 16'h8000, 1'b1, 16'hC000, 1'b0, 1'b0, 1'b0}, // R5
        '{12'h040, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R6
        '{12'h040, 16'h0001, 1'b1, 16'h0003, 1'b0, 1'b0, 1'b0}, // R6
        '{12'h0C0, 16'h1234, 1'b1, 16'h1234, 1'b1, 1'b0, 1'b0}, // R6 both rotates
        '{12'h020, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R7 wrap
        '{12'h020, 16'h7FFF, 1'b1, 16'h8000, 1'b1, 1'b0, 1'b0}, // R7
        '{12'h010, 16'h7FFF, 1'b0, 16'h7FFF, 1'b0, 1'b1, 1'b0}, // R8 sign 0
        '{12'h010, 16'h8000, 1'b0, 16'h8000, 1'b0, 1'b0, 1'b0}, // R8
        '{12'h008, 16'h8000, 1'b1, 16'h8000, 1'b1, 1'b1, 1'b0}, // R8 sign 1
        '{12'h008, 16'h0001, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0}, // R8
        '{12'h004, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0}, // R8 zero
        '{12'h004, 16'h0001, 1'b0, 16'h0001, 1'b0, 1'b0, 1'b0}, // R8
        '{12'h002, 16'h5555, 1'b0, 16'h5555, 1'b0, 1'b1, 1'b0}, // R8 ext 0
        '{12'h002, 16'h5555, 1'b1, 16'h5555, 1'b1, 1'b0, 1'b0}, // R8
        '{12'h014, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0}, // R8 two tests pass
        '{12'h024, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R8 start value
        '{12'h001, 16'hABCD, 1'b1, 16'hABCD, 1'b1, 1'b0, 1'b1}, // R9 halt
        '{12'hA00, 16'h1234, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0}, // R4 after clear
        '{12'h820, 16'h9999, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0}, // R7 after clear
        '{12'h220, 16'h0005, 1'b0, 16'hFFFB, 1'b0, 1'b0, 1'b0}, // R7 after invert
        '{12'h000, 16'h1234, 1'b1, 16'h1234, 1'b1, 1'b0, 1'b0}  // R2 empty field
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one instruction for one cycle; strobes captured mid-cycle.
    task automatic run(input logic [15:0] w, input logic [3:0] s);
        instr = w;
        step  = s;
        #1;
        cap_skip = skip_req;
        cap_halt = halt_req;
        cap_clr  = seq_clr;
        @(negedge clk);
        step  = 4'd0;
        instr = 16'h0000;
    endtask

    // Build a value through clears, extend bit and left rotates.
    task automatic load(input logic [15:0] v, input logic e);
        run(16'h7C00, 4'd3);
        for (int i = 15; i >= 0; i--)
            run(16'h7440 | (v[i] ? 16'h0100 : 16'h0000), 4'd3);
        run(16'h7400 | (e ? 16'h0100 : 16'h0000), 4'd3);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset acc", 32'(acc_q), 32'h0);
        check("R10 reset ext", 32'(ext_q), 32'h0);
        check("R1 no strobes in reset idle", {29'd0, skip_req, halt_req, seq_clr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            load(VECS[k].a0, VECS[k].e0);
            check("load setup acc", 32'(acc_q), 32'(VECS[k].a0));
            run(16'h7000 | {4'h0, VECS[k].fld}, 4'd3);
            check($sformatf("R3-R7 acc vec %0d", k), 32'(acc_q), 32'(VECS[k].xa));
            check($sformatf("ext vec %0d", k), 32'(ext_q), 32'(VECS[k].xe));
            check($sformatf("R8 skip vec %0d", k), 32'(cap_skip), 32'(VECS[k].xs));
            check($sformatf("R9 halt vec %0d", k), 32'(cap_halt), 32'(VECS[k].xh));
            check($sformatf("R2 seq clear vec %0d", k), 32'(cap_clr), 32'h1);
        end

        // R1: wrong step, indirect set, wrong class all leave state alone
        load(16'h1234, 1'b1);
        run(16'h7801, 4'd2);
        check("R1 step 2 acc", 32'(acc_q), 32'h1234);
        check("R1 step 2 strobes", {29'd0, cap_skip, cap_halt, cap_clr}, 32'h0);
        run(16'hF801, 4'd3);
        check("R1 indirect acc", 32'(acc_q), 32'h1234);
        check("R1 indirect strobes", {29'd0, cap_skip, cap_halt, cap_clr}, 32'h0);
        run(16'h6C01, 4'd3);
        check("R1 class 110 acc", 32'(acc_q), 32'h1234);
        check("R1 class 110 ext", 32'(ext_q), 32'h1);
        check("R1 class 110 strobes", {29'd0, cap_skip, cap_halt, cap_clr}, 32'h0);
        run(16'h7004, 4'd4);
        check("R1 step 4 no skip", 32'(cap_skip), 32'h0);

        // R10: reset in the middle of operation
        load(16'hBEEF, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 mid reset acc", 32'(acc_q), 32'h0);
        check("R10 mid reset ext", 32'(ext_q), 32'h0);

        // R5/R6: full right ring of 17 steps returns start
        load(16'h8421, 1'b0);
        for (int i = 0; i < 17; i++) run(16'h7080, 4'd3);
        check("R5 17-step ring acc", 32'(acc_q), 32'h8421);
        check("R5 17-step ring ext", 32'(ext_q), 32'h0);

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule